// File: doc/BRIEF.md
# Two-Wire Serial Flash Sector Writer

This block is the host side of a two-wire flash link made of one clock line and one bidirectional data line. A single start request takes a 12-bit sector number and a 4-bit target address. The block then fetches one sector of 536 bytes from a byte stream that uses a ready/valid handshake. It clocks out the write instruction, the full sector and a tail of filler clocks. It then holds the clock low long enough to reset the target, and that pulse begins the target's combined erase and program cycle. No separate erase step exists.

If polling is enabled, the block then reads the target's 16-bit status word repeatedly. Each read is a new instruction that ends with another clock-low reset. Polling stops when the ready code appears or when a poll budget runs out. Every field goes out MSB first and is clocked on the rising edge. A stall in the byte stream is absorbed by parking the clock high, because a long low level would reset the target.

Top module: `sfw_sector_writer`

## Requirements
- R1: After reset, sck and sio_oe are low, and busy, byte_ready, done and timed_out are all 0.
- R2: Every instruction starts with one wake rising edge whose data is ignored. A 56-bit header follows, MSB first: a 4-bit opcode (0010b for a write, 0001b for a status read), the 12-bit sector, the 4-bit device address, four zero bits and 32 zero bits.
- R3: After a write header, exactly 536 bytes are taken from the stream. They are sent as 4288 bits, each byte MSB first and in arrival order, with the first byte on the wire first.
- R4: After the data come exactly 16 filler rising edges with sio_out low. The whole write instruction has 4361 rising edges, counting the wake edge.
- R5: sio_oe is high at every rising edge of a write instruction, from the wake edge through the last filler edge.
- R6: After the last filler edge, sck stays low for at least RESET_CYC clock cycles with sio_oe low. If polling is off, done then pulses with timed_out low.
- R7: While the byte stream is stalled, sck is held high. Inside an instruction, no low phase lasts longer than HALF_CYC cycles.
- R8: If poll_en was low at start, no rising edge occurs after the reset pulse.
- R9: If poll_en was high at start, status reads (opcode 0001b, same sector and device) are issued after the reset pulse. During the 16 status bits sio_oe is low. The first read that returns 9999h ends the operation with done high and timed_out low.
- R10: If none of the first POLL_MAX status reads returns 9999h (for example, all return 6666h), done and timed_out pulse together after read number POLL_MAX, and no further read is issued.
- R11: In a status read, sck stays high for at least TRP_CYC cycles after the first status rising edge.
- R12: A start pulse while busy is high is ignored, and the instruction in progress runs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a sector write (sampled only when idle) |
| sector | input | 12 | Sector number to program |
| device | input | 4 | Address of the target on the shared link |
| poll_en | input | 1 | Poll status after the program trigger |
| byte_data | input | 8 | Next sector byte |
| byte_valid | input | 1 | byte_data holds a byte |
| byte_ready | output | 1 | Block accepts a byte this cycle |
| sck | output | 1 | Serial clock to the target |
| sio_out | output | 1 | Serial data driven toward the target |
| sio_oe | output | 1 | Drive enable for sio_out |
| sio_in | input | 1 | Serial data returned by the target |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse at the end of an operation |
| timed_out | output | 1 | Pulses with done when polling gave up |

## Verification
Writes are tried with a steady byte stream and with a stream that drops valid for long periods. The steady case checks the bit order and the edge count. The stalled case tells apart a clock that parks high from one that wrongly drops low or skips data. Sector and device values of all ones and all zeros, along with a mixed pattern, expose any field that is shifted, swapped or truncated. Polling is run against a target model that answers busy twice and then ready, and against one that never becomes ready. These two runs separate a correct stop on ready from a stop on the poll budget.

// File: rtl/sfw_pkg.sv
package sfw_pkg;
  localparam int HDR_BITS  = 56;
  localparam int STAT_BITS = 16;
  localparam logic [3:0]  OP_READ    = 4'h1;
  localparam logic [3:0]  OP_WRITE   = 4'h2;
  localparam logic [15:0] STAT_READY = 16'h9999;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WAKE, ST_HDR, ST_DATA, ST_FILL, ST_STAT, ST_TRP, ST_RST
  } sfw_state_e;

  // instruction header: opcode, sector, device, aux nibble, reserved word
  function automatic logic [HDR_BITS-1:0] sfw_header(input logic [3:0] op,
                                                     input logic [11:0] sect,
                                                     input logic [3:0] dev);
    return {op, sect, dev, 4'h0, 32'h0000_0000};
  endfunction
endpackage

// File: rtl/sfw_phase_gen.sv
module sfw_phase_gen #(
  parameter int HALF_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  logic [CW-1:0] cnt_q;

  assign tick = run && (cnt_q == CW'(HALF_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (!run || tick)  cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/sfw_status_cap.sv
module sfw_status_cap import sfw_pkg::*; (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 shift_en,
  input  logic                 bit_in,
  output logic [STAT_BITS-1:0] word,
  output logic                 is_ready
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        word <= '0;
    else if (clr)      word <= '0;
    else if (shift_en) word <= {word[STAT_BITS-2:0], bit_in};
  end
  assign is_ready = (word == STAT_READY);
endmodule

// File: rtl/sfw_sector_writer.sv
module sfw_sector_writer import sfw_pkg::*; #(
  parameter int HALF_CYC     = 2,
  parameter int RESET_CYC    = 64,
  parameter int TRP_CYC      = 32,
  parameter int POLL_MAX     = 8,
  parameter int SECTOR_BYTES = 536,
  parameter int FILL_CLKS    = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [11:0] sector,
  input  logic [3:0]  device,
  input  logic        poll_en,
  input  logic [7:0]  byte_data,
  input  logic        byte_valid,
  output logic        byte_ready,
  output logic        sck,
  output logic        sio_out,
  output logic        sio_oe,
  input  logic        sio_in,
  output logic        busy,
  output logic        done,
  output logic        timed_out
);
  localparam int DATA_BITS = SECTOR_BYTES * 8;
  localparam int CNT_W     = $clog2(DATA_BITS + 1);
  localparam int BYTE_W    = $clog2(SECTOR_BYTES + 1);
  localparam int DMAX      = (RESET_CYC > TRP_CYC) ? RESET_CYC : TRP_CYC;
  localparam int DW        = $clog2(DMAX + 1);
  localparam int PW        = $clog2(POLL_MAX + 1);

  sfw_state_e          st;
  logic                rd_mode, poll_q, sck_q, sio_q, oe_q, done_q, to_q;
  logic [11:0]         sect_q;
  logic [3:0]          dev_q;
  logic [HDR_BITS-1:0] hsh;
  logic [CNT_W-1:0]    cnt;
  logic [DW-1:0]       dcnt;
  logic [7:0]          sh, buf_q;
  logic [3:0]          left;
  logic                buf_full;
  logic [BYTE_W-1:0]   taken;
  logic [PW-1:0]       polls;

  // named internal events
  logic run, tick, slot_start, rise, need_byte, stall, accept, stat_shift, stat_ready;
  logic [STAT_BITS-1:0] stat_word;

  assign run        = (st == ST_WAKE) || (st == ST_HDR) || (st == ST_DATA) ||
                      (st == ST_FILL) || (st == ST_STAT);
  assign slot_start = tick && sck_q;
  assign rise       = tick && !sck_q;
  assign need_byte  = (left == 4'd0);
  assign stall      = (st == ST_DATA) && slot_start && (cnt != '0) && need_byte && !buf_full;
  assign byte_ready = (st == ST_DATA) && !buf_full && (taken != BYTE_W'(SECTOR_BYTES));
  assign accept     = byte_valid && byte_ready;
  assign stat_shift = rise && (st == ST_STAT);

  sfw_phase_gen #(.HALF_CYC(HALF_CYC)) u_phase (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick));

  sfw_status_cap u_stat (
    .clk(clk), .rst_n(rst_n), .clr(st == ST_WAKE), .shift_en(stat_shift),
    .bit_in(sio_in), .word(stat_word), .is_ready(stat_ready));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; rd_mode <= 1'b0; poll_q <= 1'b0;
      sck_q <= 1'b0; sio_q <= 1'b0; oe_q <= 1'b0;
      done_q <= 1'b0; to_q <= 1'b0;
      sect_q <= '0; dev_q <= '0; hsh <= '0; cnt <= '0; dcnt <= '0;
      sh <= '0; buf_q <= '0; left <= '0; buf_full <= 1'b0;
      taken <= '0; polls <= '0;
    end else begin
      done_q <= 1'b0;
      to_q   <= 1'b0;
      if (accept) begin
        buf_q    <= byte_data;
        buf_full <= 1'b1;
        taken    <= taken + 1'b1;
      end
      unique case (st)
        ST_IDLE: if (start) begin
          sect_q <= sector; dev_q <= device; poll_q <= poll_en;
          rd_mode <= 1'b0; taken <= '0; left <= '0; buf_full <= 1'b0;
          oe_q <= 1'b1; sio_q <= 1'b0; st <= ST_WAKE;
        end
        ST_WAKE: begin
          if (rise) sck_q <= 1'b1;
          else if (slot_start) begin
            hsh <= sfw_header(rd_mode ? OP_READ : OP_WRITE, sect_q, dev_q);
            cnt <= CNT_W'(HDR_BITS);
            st  <= ST_HDR;
          end
        end
        ST_HDR: begin
          if (rise) sck_q <= 1'b1;
          else if (slot_start) begin
            if (cnt != '0) begin
              sck_q <= 1'b0; sio_q <= hsh[HDR_BITS-1];
              hsh <= hsh << 1; cnt <= cnt - 1'b1;
            end else if (rd_mode) begin
              st <= ST_STAT; cnt <= CNT_W'(STAT_BITS); oe_q <= 1'b0;
            end else begin
              st <= ST_DATA; cnt <= CNT_W'(DATA_BITS);
            end
          end
        end
        ST_DATA: begin
          if (rise) sck_q <= 1'b1;
          else if (slot_start) begin
            if (cnt == '0) begin
              st <= ST_FILL; cnt <= CNT_W'(FILL_CLKS);
            end else if (!need_byte) begin
              sck_q <= 1'b0; sio_q <= sh[7]; sh <= sh << 1;
              left <= left - 1'b1; cnt <= cnt - 1'b1;
            end else if (buf_full) begin
              sck_q <= 1'b0; sio_q <= buf_q[7]; sh <= {buf_q[6:0], 1'b0};
              left <= 4'd7; buf_full <= 1'b0; cnt <= cnt - 1'b1;
            end
          end
        end
        ST_FILL: begin
          if (rise) sck_q <= 1'b1;
          else if (slot_start) begin
            sck_q <= 1'b0;
            if (cnt != '0) begin
              sio_q <= 1'b0; cnt <= cnt - 1'b1;
            end else begin
              oe_q <= 1'b0; dcnt <= DW'(RESET_CYC); st <= ST_RST;
            end
          end
        end
        ST_STAT: begin
          if (rise) begin
            sck_q <= 1'b1;
            if (cnt == CNT_W'(STAT_BITS - 1)) begin
              st <= ST_TRP; dcnt <= DW'(TRP_CYC);
            end
          end else if (slot_start) begin
            sck_q <= 1'b0;
            if (cnt != '0) cnt <= cnt - 1'b1;
            else begin
              dcnt <= DW'(RESET_CYC); st <= ST_RST;
            end
          end
        end
        ST_TRP: begin
          if (dcnt == '0) st <= ST_STAT;
          else            dcnt <= dcnt - 1'b1;
        end
        ST_RST: begin
          if (dcnt != '0) dcnt <= dcnt - 1'b1;
          else if (!rd_mode && !poll_q) begin
            st <= ST_IDLE; done_q <= 1'b1;
          end else if (!rd_mode || (!stat_ready && polls != PW'(POLL_MAX))) begin
            polls   <= rd_mode ? polls + 1'b1 : PW'(1);
            rd_mode <= 1'b1; oe_q <= 1'b1; sio_q <= 1'b0; st <= ST_WAKE;
          end else begin
            st <= ST_IDLE; done_q <= 1'b1; to_q <= !stat_ready;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign sck       = sck_q;
  assign sio_out   = sio_q;
  assign sio_oe    = oe_q;
  assign busy      = (st != ST_IDLE);
  assign done      = done_q;
  assign timed_out = to_q;

  assert_hold_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> sck_q);
  assert_sio_driven_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st inside {ST_WAKE, ST_HDR, ST_DATA, ST_FILL}) |-> oe_q);
  assert_reset_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RST) |-> (!sck_q && !oe_q));
  assert_full_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_DATA) && slot_start && (cnt == '0)) |-> ((taken == BYTE_W'(SECTOR_BYTES)) && need_byte));
  assert_ready_ends_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && rd_mode && !to_q) |-> stat_ready);
  assert_timeout_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    to_q |-> (done_q && polls == PW'(POLL_MAX)));
endmodule

// File: tb/sfw_sector_writer_tb.sv
module sfw_sector_writer_tb_top;
  localparam int HALF_CYC = 1, RESET_CYC = 20, TRP_CYC = 8, POLL_MAX = 3;
  localparam int NBYTES = 536;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, poll_en = 1'b0;
  logic [11:0] sector = '0;
  logic [3:0]  device = '0;
  logic [7:0]  byte_data = '0;
  logic byte_valid = 1'b0, sio_in = 1'b0;
  logic byte_ready, sck, sio_out, sio_oe, busy, done, timed_out;

  int nchk = 0, nerr = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  sfw_sector_writer #(.HALF_CYC(HALF_CYC), .RESET_CYC(RESET_CYC), .TRP_CYC(TRP_CYC),
                      .POLL_MAX(POLL_MAX)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .sector(sector), .device(device),
    .poll_en(poll_en), .byte_data(byte_data), .byte_valid(byte_valid),
    .byte_ready(byte_ready), .sck(sck), .sio_out(sio_out), .sio_oe(sio_oe),
    .sio_in(sio_in), .busy(busy), .done(done), .timed_out(timed_out));

  // ---------------- link monitor and target model ----------------
  int low_run = 100, high_run = 0, rise_idx = 0;
  logic prev_sck = 1'b0;
  logic [55:0] hdr_cap;
  logic [55:0] wr_hdr, rd_hdr;
  bit   cur_rd = 0, trp_pending = 0;
  logic [7:0] got [NBYTES];
  int sess_wr, sess_rd, wr_rises, fill_bad, oe_miss, oe_rd_bad, max_low, trp_min;
  int busy_polls = 0;
  logic [15:0] stat_val;

  always @(negedge clk) begin
    if (sck && !prev_sck) begin
      if (low_run >= 4) rise_idx = 1;
      else begin
        rise_idx++;
        if (low_run > max_low) max_low = low_run;
      end
      if (rise_idx >= 2 && rise_idx <= 57) hdr_cap = {hdr_cap[54:0], sio_out};
      if (rise_idx == 5) begin
        cur_rd = (hdr_cap[3:0] == 4'h1);
        if (cur_rd) sess_rd++; else sess_wr++;
      end
      if (rise_idx == 57) begin
        if (cur_rd) rd_hdr = hdr_cap; else wr_hdr = hdr_cap;
      end
      if (!cur_rd || rise_idx <= 5) begin
        if (!sio_oe) oe_miss++;
      end
      if (!cur_rd && rise_idx > 5) begin
        wr_rises = rise_idx;
        if (rise_idx >= 58 && rise_idx <= 57 + NBYTES*8) begin
          int k;
          k = rise_idx - 58;
          got[k/8][7 - k%8] = sio_out;
        end else if (rise_idx > 57 + NBYTES*8 && sio_out) fill_bad++;
      end
      if (cur_rd) begin
        stat_val = (sess_rd <= busy_polls) ? 16'h6666 : 16'h9999;
        if (rise_idx >= 57 && rise_idx <= 72) sio_in = stat_val[15 - (rise_idx - 57)];
        if (rise_idx >= 58 && rise_idx <= 73 && sio_oe) oe_rd_bad++;
        if (rise_idx == 58) trp_pending = 1;
      end
      low_run = 0;
    end
    if (!sck && prev_sck) begin
      if (trp_pending && high_run < trp_min) trp_min = high_run;
      trp_pending = 0;
      high_run = 0;
    end
    if (sck) high_run++; else low_run++;
    prev_sck = sck;
  end

  // ---------------- helpers ----------------
  function automatic logic [7:0] pat(input int i, input int seed);
    return (i == 0) ? 8'hC9 : 8'((i * seed + 7) ^ (i >> 3));
  endfunction

  function automatic logic [55:0] exp_hdr(input logic [3:0] op, input logic [11:0] s,
                                          input logic [3:0] d);
    logic [55:0] h;
    h = '0;
    h[55:52] = op; h[51:40] = s; h[39:36] = d;
    return h;
  endfunction

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic chk_ge(input string req, input string what, input longint act, input longint lim);
    nchk++;
    if (act < lim) begin
      nerr++;
      $display("FAIL %s %s: actual %0d expected >= %0d", req, what, act, lim);
    end
  endtask

  task automatic clear_mon();
    sess_wr = 0; sess_rd = 0; wr_rises = 0; fill_bad = 0; oe_miss = 0;
    oe_rd_bad = 0; max_low = 0; trp_min = 1000000; wr_hdr = '0; rd_hdr = '0;
  endtask

  task automatic feed(input int seed, input bit stall);
    int idx = 0, cyc = 0;
    bit pend = 0;
    while (idx < NBYTES) begin
      @(negedge clk);
      cyc++;
      if (pend) idx++;
      if (idx < NBYTES) begin
        byte_valid = !(stall && ((cyc % 50) < 23));
        byte_data  = pat(idx, seed);
        pend       = byte_valid && byte_ready;
      end else byte_valid = 1'b0;
    end
    byte_valid = 1'b0;
  endtask

  task automatic run_op(input logic [11:0] s, input logic [3:0] d, input bit poll,
                        input int seed, input bit stall, input bit extra_start,
                        output int low_at_done, output bit to_at_done, output bit oe_at_done);
    int w = 0;
    clear_mon();
    @(negedge clk);
    sector = s; device = d; poll_en = poll; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    fork
      feed(seed, stall);
      begin
        if (extra_start) begin
          repeat (3000) @(negedge clk);
          sector = ~s; start = 1'b1;
          @(negedge clk);
          start = 1'b0;
        end
      end
    join
    while (!done && w < 60000) begin
      @(negedge clk);
      w++;
    end
    low_at_done = low_run; to_at_done = timed_out; oe_at_done = sio_oe;
  endtask

  task automatic check_data(input string req, input int seed);
    int bad = 0;
    for (int i = 0; i < NBYTES; i++) if (got[i] !== pat(i, seed)) bad++;
    chk(req, "mismatching sector bytes", bad, 0);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    chk("R1", "sck after reset", sck, 0);
    chk("R1", "sio_oe after reset", sio_oe, 0);
    chk("R1", "busy/ready/done/timed_out after reset",
        {busy, byte_ready, done, timed_out}, 0);
  endtask

  task automatic t_plain_write();
    int ld; bit to, oe;
    run_op(12'hA5C, 4'h9, 0, 13, 0, 0, ld, to, oe);
    chk("R2", "write header", wr_hdr, exp_hdr(4'h2, 12'hA5C, 4'h9));
    check_data("R3", 13);
    chk("R3", "first byte is tag", got[0], 8'hC9);
    chk("R4", "rising edges in write", wr_rises, 1 + 56 + NBYTES*8 + 16);
    chk("R4", "filler bits high", fill_bad, 0);
    chk("R5", "edges with sio released", oe_miss, 0);
    chk_ge("R6", "low cycles before done", ld, RESET_CYC);
    chk("R6", "sio_oe / timed_out at done", {oe, to}, 0);
    repeat (100) @(negedge clk);
    chk("R8", "status reads without poll", sess_rd, 0);
    chk("R8", "edges after reset pulse (sck, busy)", {sck, busy}, 0);
  endtask

  task automatic t_stalled_write();
    int ld; bit to, oe;
    run_op(12'h3C1, 4'h6, 0, 91, 1, 1, ld, to, oe);
    chk_ge("R7", "allowed low phase exceeded", HALF_CYC, max_low);
    check_data("R7", 91);
    chk("R7", "rising edges in stalled write", wr_rises, 1 + 56 + NBYTES*8 + 16);
    repeat (200) @(negedge clk);
    chk("R12", "write instructions after start while busy", sess_wr, 1);
    chk("R12", "header unchanged by start while busy", wr_hdr, exp_hdr(4'h2, 12'h3C1, 4'h6));
    chk("R12", "busy after ignored start", busy, 0);
  endtask

  task automatic t_edge_addr();
    int ld; bit to, oe;
    run_op(12'hFFF, 4'h0, 0, 255, 0, 0, ld, to, oe);
    chk("R2", "header with max sector, device 0", wr_hdr, exp_hdr(4'h2, 12'hFFF, 4'h0));
    check_data("R3", 255);
    run_op(12'h000, 4'hF, 0, 1, 0, 0, ld, to, oe);
    chk("R2", "header with sector 0, device F", wr_hdr, exp_hdr(4'h2, 12'h000, 4'hF));
  endtask

  task automatic t_poll_ready();
    int ld; bit to, oe;
    busy_polls = 2;
    run_op(12'h5A0, 4'hB, 1, 37, 0, 0, ld, to, oe);
    chk("R9", "status reads until ready", sess_rd, 3);
    chk("R9", "read header", rd_hdr, exp_hdr(4'h1, 12'h5A0, 4'hB));
    chk("R9", "timed_out on ready", to, 0);
    chk("R9", "status edges with sio driven", oe_rd_bad, 0);
    chk_ge("R11", "high cycles after first status edge", trp_min, TRP_CYC);
    check_data("R3", 37);
  endtask

  task automatic t_poll_timeout();
    int ld; bit to, oe;
    busy_polls = 1000;
    run_op(12'h077, 4'h2, 1, 5, 0, 0, ld, to, oe);
    chk("R10", "status reads before giving up", sess_rd, POLL_MAX);
    chk("R10", "timed_out with done", to, 1);
    repeat (100) @(negedge clk);
    chk("R10", "no read after give-up", sess_rd, POLL_MAX);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_plain_write();
    t_stalled_write();
    t_edge_addr();
    t_poll_ready();
    t_poll_timeout();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    #(4 * 190000);
    if (!finished) begin
      finished = 1;
      nchk++; nerr++;
      $display("FAIL watchdog: run did not complete, actual hung expected finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule